// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Deserializer

The block turns a serial stream, one bit per clock, into a parallel word of `WORD_W` bits (four by default). It picks one of two serial inputs, so a test path can be looped back through the second input. The bit received first in a word lands on the least significant output bit. A free-running divide counter decides when the word register loads. In normal mode the load happens once per word. In wide mode it happens once every two words, so that two units can be chained into a double-width converter. For that chaining, the selected serial bit also leaves the block after one register stage.

Two single-cycle strobes mark the word period and the double-word period. Both are registered in the same edge that loads the word, so each strobe is high in the cycle in which the matching new word is visible.

An asynchronous sync input adjusts the word alignment. The input is synchronised and its rising edge is detected. Each rising edge makes the divide counter hold for one cycle. This moves the word boundary one bit later, so a bit that would have appeared on output bit n now appears on bit n-1.

Top module: `bitslip_deser`

## Requirements
- R1: Within a loaded word, the earliest received bit is on `par_o[0]` and the newest is on `par_o[WORD_W-1]`; the word holds the last `WORD_W` serial bits taken before the load.
- R2: With `ser_sel_i` = 1 the serial source is `ser_a_i`; with `ser_sel_i` = 0 it is `ser_b_i`.
- R3: With `mode_wide_i` = 0 the word loads once every `WORD_W` cycles, and the first load after reset comes after exactly `WORD_W` bits have been shifted in.
- R4: With `mode_wide_i` = 1 the word loads once every `2*WORD_W` cycles, and the first load after reset comes after exactly `2*WORD_W` bits.
- R5: `stb_word_o` and `stb_pair_o` are each one cycle wide. They pulse every `WORD_W` and every `2*WORD_W` cycles respectively. Each one is high in the cycle in which the word loaded under its own mode becomes visible. `stb_pair_o` is only ever high together with `stb_word_o`.
- R6: Each rising edge of `sync_i` makes the divider skip one count. The strobe interval that contains the slip is one cycle longer (`WORD_W+1`, and `2*WORD_W+1` for the pair strobe). After the slip, word boundaries fall one bit later in the stream.
- R7: A sync pulse held high for many cycles causes only one slip. A pulse must be high for at least two cycles to be seen.
- R8: While `rst_ni` is low, the divide counter, the word register, the serial shift stage and both strobes are all zero.
- R9: `ser_o` equals the selected serial input as it was sampled at the previous clock edge.
- R10: Between loads, `par_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_a_i | input | 1 | Serial input A (selected when select is high) |
| ser_b_i | input | 1 | Serial input B (selected when select is low) |
| ser_sel_i | input | 1 | Serial source select |
| mode_wide_i | input | 1 | 0: load every word period; 1: load every double period |
| sync_i | input | 1 | Asynchronous bit-slip request, one slip per rising edge |
| par_o | output | WORD_W | Parallel word, bit 0 received first |
| ser_o | output | 1 | Selected serial bit delayed one cycle |
| stb_word_o | output | 1 | One-cycle strobe each word period |
| stb_pair_o | output | 1 | One-cycle strobe each double-word period |

## Verification
The bench builds the block with `WORD_W` = 4 and `SYNC_STAGES` = 2. At these values a divider slip lands at a fixed, known distance from the strobe that starts it, so the expected interval of 5 or 9 cycles can be predicted exactly. A four-bit window is also short enough that every load can be compared against the received bit history in both modes, and across repeated short slips and one long pulse.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef struct packed {
    logic pair;
    logic word;
  } bsd_stb_t;

  function automatic int unsigned bsd_cnt_w(input int unsigned word_w);
    return $clog2(2 * word_w);
  endfunction

endpackage

// File: rtl/bsd_sync_edge.sv
module bsd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/bsd_divider.sv
module bsd_divider
  import bsd_pkg::*;
#(
  parameter int unsigned WORD_W = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     slip_i,
  input  logic     wide_i,
  output logic     upd_o,
  output bsd_stb_t stb_o
);

  localparam int unsigned CNT_W = bsd_cnt_w(WORD_W);

  logic [CNT_W-1:0] cnt_q;
  logic             hit_word, hit_pair;
  bsd_stb_t         stb_q;

  // a slip freezes the count and suppresses that cycle's load
  assign hit_word = (&cnt_q[CNT_W-2:0]) & ~slip_i;
  assign hit_pair = (&cnt_q) & ~slip_i;
  assign upd_o    = wide_i ? hit_pair : hit_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= '0;
    end else begin
      if (!slip_i) cnt_q <= cnt_q + 1'b1;
      stb_q.word <= hit_word;
      stb_q.pair <= hit_pair;
    end
  end

  assign stb_o = stb_q;

  logic [CNT_W:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (hit_word) since_q <= '0;
    else if (since_q != {(CNT_W+1){1'b1}}) since_q <= since_q + 1'b1;
  end

  AST_WORD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_word |-> since_q >= (CNT_W+1)'(WORD_W - 1)); // R3

endmodule

// File: rtl/bsd_shift_capture.sv
module bsd_shift_capture #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sin_i,
  input  logic              upd_i,
  output logic [WORD_W-1:0] par_o,
  output logic              ser_o
);

  logic [WORD_W-1:0] sr_q, sr_nxt, par_q;

  // newest bit enters at the top, so the oldest ends at bit 0
  assign sr_nxt = {sin_i, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      par_q <= '0;
    end else begin
      sr_q <= sr_nxt;
      if (upd_i) par_q <= sr_nxt;
    end
  end

  assign par_o = par_q;
  assign ser_o = sr_q[WORD_W-1];

  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(par_o)); // R10

  AST_NEWEST_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> par_o[WORD_W-1] == $past(sin_i)); // R1

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bsd_pkg::*;
#(
  parameter int unsigned WORD_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_a_i,
  input  logic              ser_b_i,
  input  logic              ser_sel_i,
  input  logic              mode_wide_i,
  input  logic              sync_i,
  output logic [WORD_W-1:0] par_o,
  output logic              ser_o,
  output logic              stb_word_o,
  output logic              stb_pair_o
);

  logic     sin_sel;
  logic     slip;
  logic     upd;
  bsd_stb_t stb;

  assign sin_sel = ser_sel_i ? ser_a_i : ser_b_i;

  bsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .rise_o (slip)
  );

  bsd_divider #(.WORD_W(WORD_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slip_i(slip),
    .wide_i(mode_wide_i),
    .upd_o (upd),
    .stb_o (stb)
  );

  bsd_shift_capture #(.WORD_W(WORD_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sin_i (sin_sel),
    .upd_i (upd),
    .par_o (par_o),
    .ser_o (ser_o)
  );

  assign stb_word_o = stb.word;
  assign stb_pair_o = stb.pair;

  AST_SER_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ser_o == $past(sin_sel)); // R9

  AST_STB_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_word_o |=> !stb_word_o); // R5

  AST_PAIR_IN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_pair_o |-> stb_word_o); // R5

endmodule

// File: tb/bitslip_deser_tb_top.sv
module bitslip_deser_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_r = 1'b0, b_r = 1'b0, sel_r = 1'b1, wide_r = 1'b0, sync_r = 1'b0;
  logic [W-1:0] par;
  logic         ser, stb_w, stb_p;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;
  bit  hist[$];
  int  gap_w = 0, gap_p = 0, ex_w = 0, ex_p = 0;
  string slip_tag = "R6";
  logic [W-1:0] prev_par = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bitslip_deser #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ser_a_i    (a_r),
    .ser_b_i    (b_r),
    .ser_sel_i  (sel_r),
    .mode_wide_i(wide_r),
    .sync_i     (sync_r),
    .par_o      (par),
    .ser_o      (ser),
    .stb_word_o (stb_w),
    .stb_pair_o (stb_p)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic new_data();
    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    a_r   = lfsr[0];
    b_r   = lfsr[5] ^ ~lfsr[0];
  endtask

  task automatic tick();
    bit sin;
    bit upd;
    logic [W-1:0] exp_w;
    new_data();
    @(posedge clk);
    sin = sel_r ? a_r : b_r;
    hist.push_back(sin);
    gap_w++;
    gap_p++;
    @(negedge clk);
    chk(ser == sin, sel_r ? "R9" : "R2", ser, sin);
    if (stb_w) begin
      chk(gap_w == W + ex_w, ex_w != 0 ? slip_tag : "R3", gap_w, W + ex_w);
      gap_w = 0; ex_w = 0;
    end else if (gap_w >= W + ex_w) begin
      chk(1'b0, "R5", gap_w, W + ex_w);
      gap_w = 0; ex_w = 0;
    end
    if (stb_p) begin
      chk(stb_w, "R5", stb_w, 1);
      chk(gap_p == 2*W + ex_p, ex_p != 0 ? slip_tag : "R4", gap_p, 2*W + ex_p);
      gap_p = 0; ex_p = 0;
    end else if (gap_p >= 2*W + ex_p) begin
      chk(1'b0, "R5", gap_p, 2*W + ex_p);
      gap_p = 0; ex_p = 0;
    end
    upd = wide_r ? stb_p : stb_w;
    if (upd) begin
      for (int i = 0; i < W; i++) exp_w[i] = hist[hist.size() - W + i];
      chk(par == exp_w, wide_r ? "R4" : "R1", par, exp_w);
    end else begin
      chk(par == prev_par, "R10", par, prev_par);
    end
    prev_par = par;
    while (hist.size() > 16) void'(hist.pop_front());
  endtask

  task automatic do_reset(input bit wide);
    @(negedge clk);
    rst_n  = 1'b0;
    sync_r = 1'b0;
    wide_r = wide;
    repeat (3) begin
      @(negedge clk);
      chk(par == '0 && !stb_w && !stb_p && !ser, "R8", {par, stb_w, stb_p, ser}, 0);
    end
    rst_n = 1'b1;
    hist.delete();
    gap_w = 0; gap_p = 0; ex_w = 0; ex_p = 0;
    prev_par = '0;
  endtask

  task automatic wait_word();
    int guard = 0;
    do begin
      tick();
      guard++;
    end while (!stb_w && guard < 40);
  endtask

  task automatic slip_pulse(input int len, input string tag);
    wait_word();
    slip_tag = tag;
    sync_r = 1'b1;
    ex_w = 1; ex_p = 1;
    repeat (len) tick();
    sync_r = 1'b0;
    repeat (12) tick();
  endtask

  initial begin
    do_reset(1'b0);
    sel_r = 1'b1;
    repeat (40) tick();
    sel_r = 1'b0;
    repeat (40) tick();
    sel_r = 1'b1;
    repeat (3) slip_pulse(2, "R6");
    slip_pulse(10, "R7");
    repeat (16) tick();
    do_reset(1'b1);
    repeat (60) tick();
    repeat (2) slip_pulse(3, "R6");
    slip_pulse(11, "R7");
    sel_r = 1'b0;
    repeat (24) tick();
    do_reset(1'b0);
    repeat (8) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule